// File: doc/BRIEF.md
# Periodic Match Timer with Postscaler

This block is one timer channel. A free-running up-counter moves forward on a 32.768 kHz tick enable. It compares its value against a match value that a 3-bit scale code selects from a fixed, non-linear table. On every match the counter returns to zero and keeps going, so matches repeat at a fixed period.

Each match also sets a sticky status flag and steps a second-stage interval counter. When that interval counter reaches the programmed 8-bit interval, it wraps to zero and emits a one-cycle fire pulse. Software drives the channel through a small register-style port with these strobes:
- a configuration write that loads the scale/interval pair and restarts both counters;
- a run write that starts or stops the channel;
- a direct counter load;
- a write-one-to-clear for the status flag.

The interrupt output is high while the channel is running and the status flag is set.

Top module: `match_timer_chan`

## Requirements
- R1: The main counter changes only on a cycle where tick_en is high and the channel is running, or on a configuration write, a start or a counter load. On any other cycle it holds its value.
- R2: The scale code selects the match value as follows: code 0 gives 0, 1 gives 1, 2 gives 8, 3 gives 32, 4 gives 64, 5 gives 128, 6 gives 256, and code 7 gives 0. The channel fires every (match+1) ticks when the interval is 1.
- R3: On a tick where the counter equals the match value, the counter becomes 0 and keeps running. With a match value of 0, every tick is a match.
- R4: Each match sets match_sts. A cycle with sts_clr high and no match clears it. If a match and a clear fall in the same cycle, the flag stays set.
- R5: irq is high exactly when the channel is running and match_sts is 1.
- R6: Each match increments ivl_count. When the incremented value is greater than or equal to the programmed interval, ivl_count becomes 0 and fire is high for one cycle, the cycle after the tick edge. An interval of 0 behaves like 1.
- R7: A configuration write (cfg_wr) does three things: it clears ivl_count, reloads the match value from cfg_scale and the interval from cfg_interval, and restarts the main counter from 0.
- R8: A stop (run_wr=1, run_val=0) turns the channel off, drops irq on the next cycle and freezes both counters, but leaves match_sts unchanged. A start (run_wr=1, run_val=1) clears both counters and turns the channel on.
- R9: After reset the channel is off: the counters are zero, and match_sts, irq and fire are 0.
- R10: A counter load (cnt_wr) writes cnt_wdata into the main counter. The next match comparison uses the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| cfg_wr | input | 1 | Load the scale/interval pair and restart the counters |
| cfg_scale | input | 3 | Scale code selecting the match value |
| cfg_interval | input | 8 | Matches per fire pulse |
| run_wr | input | 1 | Run control write strobe |
| run_val | input | 1 | 1 = start, 0 = stop (used with run_wr) |
| cnt_wr | input | 1 | Main counter load strobe |
| cnt_wdata | input | CNT_W (16) | Value loaded into the main counter |
| sts_clr | input | 1 | Write-one-to-clear for the status flag |
| ivl_count | output | 8 | Current interval counter value |
| match_sts | output | 1 | Sticky match status flag |
| irq | output | 1 | Interrupt request |
| fire | output | 1 | One-cycle postscaled event pulse |

## Verification
A wrong match register or a wrong scale decode shows up as a fire pulse in the wrong cycle. For the largest scale this can take up to 257 ticks to appear, so the bench lets every scale code run through at least one full period. A wrong interval counter shows up at once on ivl_count after the next match, and as a fire pulse that is missing or early. A status or run bit that is wrong appears on irq in the cycle after the stimulus. The scoreboard predicts the exact cycle of every fire pulse, so a pulse that is early, late, extra or missing is reported within one tick of the fault.

// File: rtl/mt_pkg.sv
package mt_pkg;

  localparam int SCALE_W = 3;

  // Fixed non-linear scale table; unused codes select a zero match.
  function automatic int unsigned scale_to_match(input logic [SCALE_W-1:0] code);
    int unsigned m;
    case (code)
      3'd0:    m = 0;
      3'd1:    m = 1;
      3'd2:    m = 8;
      3'd3:    m = 32;
      3'd4:    m = 64;
      3'd5:    m = 128;
      3'd6:    m = 256;
      default: m = 0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mt_counter.sv
module mt_counter
  import mt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               run,
  input  logic               restart,
  input  logic               cfg_ld,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic               ld_en,
  input  logic [CNT_W-1:0]   ld_val,
  output logic               hit
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] match_q, match_nxt;
  logic             adv;

  assign adv = run && tick_en;

  always_comb begin
    match_nxt = match_q;
    if (cfg_ld) match_nxt = CNT_W'(scale_to_match(cfg_scale));
  end

  always_comb begin
    cnt_nxt = cnt_q;
    hit     = 1'b0;
    if (restart) begin
      cnt_nxt = '0;
    end else if (ld_en) begin
      cnt_nxt = ld_val;
    end else if (adv) begin
      if (cnt_q == match_q) begin
        cnt_nxt = '0;
        hit     = 1'b1;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= '0;
    end else begin
      cnt_q   <= cnt_nxt;
      match_q <= match_nxt;
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart && !ld_en) |=> $stable(cnt_q));

  // R3
  match_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !restart && !ld_en && cnt_q == match_q) |=> (cnt_q == '0));

endmodule

// File: rtl/mt_postscale.sv
module mt_postscale #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  input  logic             cfg_ld,
  input  logic [IVL_W-1:0] cfg_ivl,
  output logic [IVL_W-1:0] ivl_count,
  output logic             fire
);

  logic [IVL_W-1:0] ivl_q, ivl_nxt;
  logic [IVL_W-1:0] lim_q, lim_nxt;
  logic             fire_q, fire_nxt;
  logic [IVL_W:0]   inc;

  assign inc = {1'b0, ivl_q} + 1'b1;

  always_comb begin
    lim_nxt = lim_q;
    if (cfg_ld) lim_nxt = cfg_ivl;
  end

  always_comb begin
    ivl_nxt  = ivl_q;
    fire_nxt = 1'b0;
    if (clr) begin
      ivl_nxt = '0;
    end else if (hit) begin
      if (inc >= {1'b0, lim_q}) begin
        ivl_nxt  = '0;
        fire_nxt = 1'b1;
      end else begin
        ivl_nxt = inc[IVL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      lim_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      ivl_q  <= ivl_nxt;
      lim_q  <= lim_nxt;
      fire_q <= fire_nxt;
    end
  end

  assign ivl_count = ivl_q;
  assign fire      = fire_q;

  // R6
  fire_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (ivl_q == '0));

  // R7
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ivl_q == '0 && !fire_q));

endmodule

// File: rtl/mt_status.sv
module mt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_req,
  input  logic start,
  input  logic stop,
  output logic on,
  output logic sts,
  output logic irq
);

  logic sts_q, sts_nxt;
  logic on_q, on_nxt;

  always_comb begin
    sts_nxt = sts_q;
    if (hit)          sts_nxt = 1'b1;
    else if (clr_req) sts_nxt = 1'b0;
  end

  always_comb begin
    on_nxt = on_q;
    if (start)     on_nxt = 1'b1;
    else if (stop) on_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      on_q  <= 1'b0;
    end else begin
      sts_q <= sts_nxt;
      on_q  <= on_nxt;
    end
  end

  assign on  = on_q;
  assign sts = sts_q;
  assign irq = on_q && sts_q;

  // R4
  sts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(hit));

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !irq);

endmodule

// File: rtl/match_timer_chan.sv
module match_timer_chan
  import mt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IVL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               cfg_wr,
  input  logic [SCALE_W-1:0] cfg_scale,
  input  logic [IVL_W-1:0]   cfg_interval,
  input  logic               run_wr,
  input  logic               run_val,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               sts_clr,
  output logic [IVL_W-1:0]   ivl_count,
  output logic               match_sts,
  output logic               irq,
  output logic               fire
);

  logic start, stop, restart, run, hit;

  assign start   = run_wr && run_val;
  assign stop    = run_wr && !run_val;
  assign restart = cfg_wr || start;

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .run       (run),
    .restart   (restart),
    .cfg_ld    (cfg_wr),
    .cfg_scale (cfg_scale),
    .ld_en     (cnt_wr),
    .ld_val    (cnt_wdata),
    .hit       (hit)
  );

  mt_postscale #(.IVL_W(IVL_W)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (restart),
    .hit       (hit),
    .cfg_ld    (cfg_wr),
    .cfg_ivl   (cfg_interval),
    .ivl_count (ivl_count),
    .fire      (fire)
  );

  mt_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .clr_req (sts_clr),
    .start   (start),
    .stop    (stop),
    .on      (run),
    .sts     (match_sts),
    .irq     (irq)
  );

  // R5
  irq_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> match_sts);

endmodule

// File: tb/match_timer_chan_bench.sv
module match_timer_chan_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_scale = '0;
  logic [7:0]  cfg_interval = '0;
  logic        run_wr = 1'b0;
  logic        run_val = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        sts_clr = 1'b0;
  logic [7:0]  ivl_count;
  logic        match_sts, irq, fire;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];

  // bench reference model state
  int m_cnt = 0, m_match = 0, m_ivl = 0, m_lim = 0, m_tick = 0;
  bit m_on = 1'b0;

  match_timer_chan u_match_timer_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_wr(cfg_wr),
    .cfg_scale(cfg_scale), .cfg_interval(cfg_interval), .run_wr(run_wr),
    .run_val(run_val), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .sts_clr(sts_clr), .ivl_count(ivl_count), .match_sts(match_sts),
    .irq(irq), .fire(fire)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int spec_match(input int code);
    case (code)
      1: return 1;
      2: return 8;
      3: return 32;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: each fire pulse must match the predicted cycle
  always @(negedge clk) begin
    if (rst_n && fire && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual fire at cycle %0d expected no fire", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R6: actual fire at cycle %0d expected cycle %0d", cyc, e);
        end
      end
    end
  end

  task automatic do_cfg(input int scale, input int ivl);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_scale = 3'(scale); cfg_interval = 8'(ivl);
    m_match = spec_match(scale); m_lim = ivl; m_cnt = 0; m_ivl = 0;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_run(input bit v);
    @(negedge clk);
    run_wr = 1'b1; run_val = v;
    m_on = v;
    if (v) begin m_cnt = 0; m_ivl = 0; end
    @(negedge clk);
    run_wr = 1'b0;
  endtask

  task automatic do_load(input int v);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = 16'(v);
    m_cnt = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  // driver: pulse ticks and push predicted fire cycles
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      if (m_on) begin
        if (m_cnt == m_match) begin
          m_cnt = 0;
          m_ivl++;
          if (m_ivl >= m_lim) begin
            m_ivl = 0;
            exp_q.push_back(cyc + 1);
          end
        end else begin
          m_cnt = (m_cnt + 1) & 16'hffff;
        end
      end
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sts", int'(match_sts), 0);
    chk("R9 irq", int'(irq), 0);
    chk("R9 fire", int'(fire), 0);
    chk("R9 ivl", int'(ivl_count), 0);
    rst_n = 1'b1;
    ticks(4);
    chk("R9 idle no status", int'(match_sts), 0);

    // R3 zero match fires each tick; interval 3
    do_cfg(0, 3);
    do_run(1'b1);
    ticks(7);
    chk("R6 ivl_count", int'(ivl_count), m_ivl);
    chk("R4 sts set", int'(match_sts), 1);
    chk("R5 irq on", int'(irq), 1);
    do_clr();
    chk("R4 sts cleared", int'(match_sts), 0);
    chk("R5 irq off", int'(irq), 0);

    // R7 reconfigure clears interval counter
    ticks(1);
    do_cfg(2, 2);
    chk("R7 ivl cleared", int'(ivl_count), 0);
    ticks(40);
    chk("R2 scale2 ivl", int'(ivl_count), m_ivl);

    // R1 no ticks: nothing moves
    hold = int'(ivl_count);
    repeat (20) @(negedge clk);
    chk("R1 ivl held", int'(ivl_count), hold);

    // R2 code 7 means match 0
    do_cfg(7, 1);
    ticks(5);
    // R2 largest scale
    do_cfg(6, 1);
    ticks(260);
    // R2 mid scales
    do_cfg(4, 2);
    ticks(140);
    chk("R2 scale4 ivl", int'(ivl_count), m_ivl);

    // R10 counter load lands on the match value
    do_cfg(3, 1);
    do_load(32);
    ticks(1);
    ticks(3);

    // R6 interval 0 acts like 1
    do_cfg(0, 0);
    ticks(3);
    chk("R6 ivl zero", int'(ivl_count), 0);

    // R8 stop
    do_cfg(0, 5);
    ticks(2);
    chk("R4 sts before stop", int'(match_sts), 1);
    do_run(1'b0);
    chk("R8 irq low", int'(irq), 0);
    chk("R8 sts kept", int'(match_sts), 1);
    hold = int'(ivl_count);
    ticks(10);
    chk("R8 ivl frozen", int'(ivl_count), hold);
    do_run(1'b1);
    chk("R8 start clears ivl", int'(ivl_count), 0);
    chk("R8 irq back", int'(irq), 1);
    ticks(6);

    repeat (4) @(negedge clk);
    chk("R6 all fires seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule